// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block connects an on-chip master to an external asynchronous static RAM of 65536 sixteen-bit words. The master issues one request at a time through a valid/ready request channel. Each request carries a direction, a 16-bit word address, 16 bits of write data and a two-bit lane mask. The controller answers on a valid/ready response channel. The memory side has three active-low strobes: chip select, write enable and output enable. It also has one active-low lane strobe per byte, a separate data output and data input path, and a drive enable that the pad ring uses to control the tri-state data bus.

The speed grade parameter selects an access time of 100, 120 or 150 ns. The clock period parameter is given in picoseconds. From these two values the controller derives its cycle counts by rounding up, so that each timing window is never shorter than the device needs.

The request channel accepts a request only while the controller is idle. The response channel holds `rsp_valid` and `rsp_rdata` steady until `rsp_ready` is seen. A new request is accepted only after the previous response has been taken, so back-pressure on the response channel stalls the request channel.

Top module: `sram_byte_ctrl`

## Requirements
- R1: Out of reset and whenever idle, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are high and both bits of `mem_be_n` are high. `mem_dq_oe` is low, `req_ready` is high, and `busy` and `rsp_valid` are low.
- R2: `req_mask` bit 0 selects the lower lane, which is data bits 7:0 driven through `mem_be_n[0]`. Bit 1 selects the upper lane, which is bits 15:8 driven through `mem_be_n[1]`. While `mem_cs_n` is low, `mem_be_n` equals the inverted mask of the current request.
- R3: A write holds `mem_we_n` low for exactly WR_CYC consecutive cycles, where WR_CYC = ceil(access time / clock period), which is 25 at 100 ns and 4 ns. During that time `mem_cs_n` is low and `mem_oe_n` is high.
- R4: During a write, `mem_dq_oe` is high starting one cycle before `mem_we_n` falls and lasting until one cycle after it rises. Over that whole window `mem_dq_o` and `mem_addr` do not change.
- R5: `mem_oe_n` is never low while `mem_dq_oe` is high. In the cycle before `mem_oe_n` falls, `mem_dq_oe` is low.
- R6: A read holds `mem_oe_n` low for exactly RD_CYC = ceil(access time / clock period) cycles. The response data is `mem_dq_i` sampled in the last of those cycles, with the lanes outside the mask returned as zero. A write response carries zero data.
- R7: A request with a mask of zero completes with `rsp_valid` in the cycle after it is accepted and drives no strobe low. It returns zero data and leaves the memory contents unchanged.
- R8: `rsp_valid` and `rsp_rdata` stay unchanged while `rsp_ready` is low. `req_ready` is low and `busy` is high from the cycle after a request is accepted until its response is taken.
- R9: After every access, `mem_cs_n` stays high for at least REC_CYC = ceil(a quarter of the access time / clock period) cycles before the next access. At 100 ns and 4 ns this is 7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high together with rsp_valid |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| busy | output | 1 | An access is in progress or its response is pending |
| mem_addr | output | 16 | Memory address |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Data pad drive enable |
| mem_dq_i | input | 16 | Data from the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane strobes, active low, bit 0 lower byte |

## Verification
A wrong sequencer state shows on the strobe pins within the same cycle. Examples are a write pulse one cycle short or long, output enable overlapping the data drivers, or chip select rising with no recovery gap. Pin monitors measure every strobe window against the derived counts and check each one as it closes. A wrong lane decode or a bad capture cycle corrupts memory contents or response data. That fault appears at the response port on the next read of the affected address, and the scoreboard compares against a shadow image that it builds from the requirements alone. A response-hold fault shows in the first stalled cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_RTRN,
    ST_RWAIT,
    ST_REC,
    ST_RESP
  } seq_st_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int grade_ns(input int grade);
    case (grade)
      1:       return 120;
      2:       return 150;
      default: return 100;
    endcase
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic [LANES-1:0] mask,
  input  logic             lane_on,
  input  logic [DW-1:0]    dq_in,
  output logic [LANES-1:0] be_n,
  output logic [DW-1:0]    rd_masked
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be_n[g]                     = ~(lane_on & mask[g]);
    assign rd_masked[g*LANE_W +: LANE_W] = mask[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int RD_CYC  = 25,
  parameter int WR_CYC  = 25,
  parameter int REC_CYC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             req_write,
  input  logic             mask_zero,
  input  logic             rsp_fire,
  input  logic             tmr_done,
  output seq_st_t          st,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             drv_en,
  output logic             capture
);
  seq_st_t nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st)
      ST_IDLE:  if (req_fire) nxt = mask_zero ? ST_RESP : (req_write ? ST_WSET : ST_RTRN);
      ST_WSET:  begin nxt = ST_WPUL; tmr_load = 1'b1; tmr_val = CNT_W'(WR_CYC - 1); end
      ST_WPUL:  if (tmr_done) nxt = ST_WHLD;
      ST_WHLD:  begin nxt = ST_REC; tmr_load = 1'b1; tmr_val = CNT_W'(REC_CYC - 1); end
      ST_RTRN:  begin nxt = ST_RWAIT; tmr_load = 1'b1; tmr_val = CNT_W'(RD_CYC - 1); end
      ST_RWAIT: if (tmr_done) begin
                  nxt = ST_REC; tmr_load = 1'b1; tmr_val = CNT_W'(REC_CYC - 1);
                end
      ST_REC:   if (tmr_done) nxt = ST_RESP;
      ST_RESP:  if (rsp_fire) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign cs_n    = !(st inside {ST_WSET, ST_WPUL, ST_WHLD, ST_RTRN, ST_RWAIT});
  assign we_n    = (st != ST_WPUL);
  assign oe_n    = (st != ST_RWAIT);
  assign drv_en  = (st inside {ST_WSET, ST_WPUL, ST_WHLD});
  assign capture = (st == ST_RWAIT) && tmr_done;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (cs_n && we_n && oe_n && !drv_en));
  // R3
  we_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cs_n && oe_n));
  // R4
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (drv_en && !cs_n));
  // R5
  oe_nodrv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !drv_en);
  // R5
  oe_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> $past(!drv_en));
endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int CLK_PS      = 4000,
  parameter int SPEED_GRADE = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [DATA_W/8-1:0]  req_mask,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 busy,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_dq_o,
  output logic                 mem_dq_oe,
  input  logic [DATA_W-1:0]    mem_dq_i,
  output logic                 mem_cs_n,
  output logic                 mem_we_n,
  output logic                 mem_oe_n,
  output logic [DATA_W/8-1:0]  mem_be_n
);
  localparam int LANES     = DATA_W / 8;
  localparam int ACCESS_PS = grade_ns(SPEED_GRADE) * 1000;
  localparam int RD_CYC    = ceil_div(ACCESS_PS, CLK_PS);
  localparam int WR_CYC    = ceil_div(ACCESS_PS, CLK_PS);
  localparam int REC_RAW   = ceil_div(ACCESS_PS / 4, CLK_PS);
  localparam int REC_CYC   = (REC_RAW < 1) ? 1 : REC_RAW;
  localparam int MAX_CYC   = (RD_CYC > REC_CYC) ? RD_CYC : REC_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  seq_st_t             st;
  logic                req_fire, rsp_fire, tmr_load, tmr_done, capture, lane_on;
  logic [CNT_W-1:0]    tmr_val;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q, rd_masked;
  logic [LANES-1:0]    mask_q;
  logic                write_q;

  assign req_ready = (st == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign rsp_valid = (st == ST_RESP);
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign busy      = !req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      write_q <= 1'b0;
      rdata_q <= '0;
    end else if (req_fire) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
      write_q <= req_write;
      rdata_q <= '0;
    end else if (capture && !write_q) begin
      rdata_q <= rd_masked;
    end
  end

  sram_seq #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .REC_CYC(REC_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_write(req_write),
    .mask_zero(req_mask == '0), .rsp_fire(rsp_fire), .tmr_done(tmr_done),
    .st(st), .tmr_load(tmr_load), .tmr_val(tmr_val), .cs_n(mem_cs_n),
    .we_n(mem_we_n), .oe_n(mem_oe_n), .drv_en(mem_dq_oe), .capture(capture)
  );

  sram_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  assign lane_on = !mem_cs_n;

  sram_lane_map #(.LANES(LANES), .LANE_W(8)) u_lanes (
    .mask(mask_q), .lane_on(lane_on), .dq_in(mem_dq_i),
    .be_n(mem_be_n), .rd_masked(rd_masked)
  );

  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign rsp_rdata = rdata_q;

  // R2
  lane_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> (mem_be_n != {LANES{1'b1}}));
  // R7
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_mask == '0) |=> (rsp_valid && mem_cs_n));
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: tb/tb_sram_byte_ctrl.sv
module tb_sram_byte_ctrl;
  localparam int TB_CLK_PS = 4000;
  localparam int TB_ACC_PS = 100000;
  localparam int EXP_WR    = (TB_ACC_PS + TB_CLK_PS - 1) / TB_CLK_PS;
  localparam int EXP_RD    = EXP_WR;
  localparam int EXP_REC   = (TB_ACC_PS / 4 + TB_CLK_PS - 1) / TB_CLK_PS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rsp_valid, busy, mem_dq_oe, mem_cs_n, mem_we_n, mem_oe_n;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_o, mem_dq_i;
  logic [1:0]  mem_be_n;

  always #2 clk = ~clk;

  sram_byte_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .busy(busy), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model
  logic [15:0] mem_m [int];
  logic [15:0] shadow [int];

  function automatic logic [15:0] mget(input logic [15:0] a);
    return mem_m.exists(int'(a)) ? mem_m[int'(a)] : 16'h0000;
  endfunction
  function automatic logic [15:0] sget(input logic [15:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
  endfunction

  always @(*) begin
    logic [15:0] v;
    v = 16'hDEAD;
    if (mem_cs_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1) begin
      v = mget(mem_addr);
      if (mem_be_n[0]) v[7:0]  = 8'hA5;
      if (mem_be_n[1]) v[15:8] = 8'hA5;
    end
    mem_dq_i = v;
  end

  always @(posedge mem_we_n) begin
    if (rst_n && mem_cs_n === 1'b0) begin
      logic [15:0] v;
      v = mget(mem_addr);
      if (!mem_be_n[0]) v[7:0]  = mem_dq_o[7:0];
      if (!mem_be_n[1]) v[15:8] = mem_dq_o[15:8];
      mem_m[int'(mem_addr)] = v;
    end
  end

  // scoreboard
  logic [15:0] exp_q [$];
  logic [1:0]  cur_mask = 2'b00;
  bit bp_on = 0;
  int bp_cnt = 0;
  int strobe_cnt = 0;

  initial forever begin
    @(posedge clk); #1;
    bp_cnt++;
    rsp_ready = bp_on ? (bp_cnt % 3 == 0) : 1'b1;
  end

  // monitor
  int we_len = 0, oe_len = 0, cs_hi_len = 0;
  bit seen_acc = 0;
  logic prev_cs = 1, prev_oe_drv = 0, prev_oe = 1, prev_rv = 0, prev_rr = 1;
  logic [15:0] prev_dqo = 0, prev_rd = 0, hold_d = 0, hold_a = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_cs_n || !mem_we_n || !mem_oe_n || mem_be_n != 2'b11) strobe_cnt++;
      if (!mem_oe_n && mem_dq_oe) chk(0, "R5 oe low while driving", 1, 0);
      // write window
      if (!mem_we_n) begin
        if (we_len == 0) begin
          chk(prev_oe_drv && prev_dqo == mem_dq_o, "R4 drive before we fall", {15'd0, prev_oe_drv}, 1);
          hold_d = mem_dq_o; hold_a = mem_addr;
        end
        if (!mem_dq_oe || mem_dq_o != hold_d || mem_addr != hold_a)
          chk(0, "R4 data/addr stable during we", mem_dq_o, hold_d);
        we_len++;
      end else if (we_len != 0) begin
        chk(we_len == EXP_WR, "R3 we low length", we_len, EXP_WR);
        chk(mem_dq_oe && mem_dq_o == hold_d && mem_addr == hold_a, "R4 hold after we rise", mem_dq_o, hold_d);
        we_len = 0;
      end
      // read window
      if (!mem_oe_n) begin
        if (oe_len == 0) chk(!prev_oe_drv, "R5 drivers off before oe fall", {15'd0, prev_oe_drv}, 0);
        oe_len++;
      end else if (oe_len != 0) begin
        chk(oe_len == EXP_RD, "R6 oe low length", oe_len, EXP_RD);
        oe_len = 0;
      end
      // lanes and recovery
      if (!mem_cs_n && prev_cs) begin
        chk(mem_be_n == ~cur_mask, "R2 lane strobes", mem_be_n, ~cur_mask);
        if (seen_acc) chk(cs_hi_len >= EXP_REC, "R9 recovery gap", cs_hi_len, EXP_REC);
        seen_acc = 1;
      end
      if (!mem_cs_n && mem_be_n != ~cur_mask) chk(0, "R2 lane strobes mid access", mem_be_n, ~cur_mask);
      cs_hi_len = mem_cs_n ? cs_hi_len + 1 : 0;
      // response hold
      if (prev_rv && !prev_rr)
        chk(rsp_valid && rsp_rdata == prev_rd, "R8 response held", rsp_rdata, prev_rd);
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) chk(0, "R6 unexpected response", rsp_rdata, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e, "R6 response data", rsp_rdata, e);
        end
      end
      prev_cs = mem_cs_n; prev_oe_drv = mem_dq_oe; prev_oe = mem_oe_n;
      prev_dqo = mem_dq_o; prev_rv = rsp_valid; prev_rr = rsp_ready; prev_rd = rsp_rdata;
    end
  end

  task automatic send(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    logic [15:0] e;
    while (!req_ready) begin @(posedge clk); #1; end
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    cur_mask = m;
    e = 16'h0000;
    if (wr) begin
      e = sget(a);
      if (m[0]) e[7:0]  = d[7:0];
      if (m[1]) e[15:8] = d[15:8];
      shadow[int'(a)] = e;
      e = 16'h0000;
    end else begin
      if (m[0]) e[7:0]  = sget(a) >> 0;
      if (m[1]) e[15:8] = sget(a) >> 8;
    end
    exp_q.push_back(e);
    @(posedge clk); #1;
    req_valid = 0;
    chk(busy && !req_ready, "R8 busy after accept", {30'd0, busy, req_ready}, 32'h2);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !req_ready) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(mem_cs_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
        "R1 strobes idle in reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 6'b111110);
    rst_n = 1;
    @(posedge clk); #1;
    chk(req_ready && !busy && !rsp_valid, "R1 idle handshake", {req_ready, busy, rsp_valid}, 3'b100);

    send(1, 16'h1234, 16'hBEEF, 2'b11);
    send(0, 16'h1234, 16'h0000, 2'b11);
    send(1, 16'h1234, 16'h7711, 2'b01);
    send(1, 16'h1234, 16'h2299, 2'b10);
    send(0, 16'h1234, 16'h0000, 2'b11);
    send(0, 16'h1234, 16'h0000, 2'b01);
    send(0, 16'h1234, 16'h0000, 2'b10);
    drain();
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle after traffic",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);

    // R7 zero mask: no strobe, no change
    begin
      int snap;
      drain();
      snap = strobe_cnt;
      send(1, 16'h1234, 16'h0000, 2'b00);
      chk(rsp_valid, "R7 zero-mask response next cycle", {31'd0, rsp_valid}, 1);
      send(0, 16'h1234, 16'h0000, 2'b00);
      drain();
      chk(strobe_cnt == snap, "R7 no strobe activity", strobe_cnt, snap);
    end
    send(0, 16'h1234, 16'h0000, 2'b11);

    // address extremes
    send(1, 16'h0000, 16'h0F0F, 2'b11);
    send(1, 16'hFFFF, 16'hF00D, 2'b11);
    send(0, 16'h0000, 16'h0000, 2'b11);
    send(0, 16'hFFFF, 16'h0000, 2'b10);

    // back-pressure on responses
    bp_on = 1;
    for (int i = 0; i < 6; i++) begin
      send(1, 16'h0100 + 16'(i), 16'hA000 + 16'(i * 17), (i % 3 == 0) ? 2'b01 : 2'b11);
      send(0, 16'h0100 + 16'(i), 16'h0000, 2'b11);
    end
    bp_on = 0;
    drain();

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R8 actual=%h expected=%h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule